// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers interrupt requests for a processor that has two interrupt inputs, a fast one and a normal one. It has one fast source, which comes from an external pin through a two-flop synchronizer, and up to 31 normal sources. The normal sources are level-sensitive and already synchronous to the clock. Each source has its own enable bit. Each normal source also has a 3-bit priority level, and level 0 keeps that source silent.

Software uses a small register port. It reads the vector register to learn which source to serve. That read also acknowledges the source: it saves the running service level on an 8-entry level stack and raises the running level to the level of the source. When the handler finishes, software writes the end-of-service register, which restores the saved level. While a level is being served, the normal output stays low unless a pending, enabled source has a strictly higher level. This is how nesting by level works.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are low. The service level (address 0x04, bits [2:0]) is 0, the normal enable word (address 0x00) is 0 and the fast enable (address 0x01, bit 0) is 0.
- R2: Normal source k can raise irq_o only while its request input is high, its enable bit k at address 0x00 is 1, and its level is nonzero.
- R3: A source whose level is 0 never raises irq_o and is never reported by the vector register.
- R4: Reading address 0x02 returns the pending, enabled source with the highest level. Bits [4:0] hold the source number and bit 8 is 1 when a source is reported.
- R5: When several eligible sources share the highest level, the lowest-numbered one is reported.
- R6: A vector read that reports a source sets the service level to that source's level from the next cycle.
- R7: While a level is being served, irq_o is low in the same cycle whenever no eligible source has a level strictly above it.
- R8: A source with a level above the one being served raises irq_o, and acknowledging it nests one level deeper.
- R9: A write to address 0x03 restores the level that was saved by the most recent acknowledge. With nothing saved, the write leaves the level at 0.
- R10: A vector read while irq_o is low returns bit 8 = 0 and does not change the service level.
- R11: fiq_o equals the fast source ANDed with the fast enable bit. The source is delayed by two clock edges and fiq_o does not depend on the service level.
- R12: The level of source k is written and read at address 0x10+k, bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 31 | Normal request lines, one per source |
| fiq_src_i | input | 1 | External fast request pin |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
The hardest state to reach is a nested stack two levels deep, with a lower-level request still pending underneath it. That pending request must stay invisible until the restores unwind past its level. The bench builds this state in steps. It raises several sources at different levels and acknowledges the highest one. It drops that source and raises a level-7 source on top. It then unwinds with end-of-service writes, checking irq_o and the service level after each write, until the lower level reappears at the vector register.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_MASK  = 6'h00;
  localparam logic [ADDR_W-1:0] A_FEN   = 6'h01;
  localparam logic [ADDR_W-1:0] A_VEC   = 6'h02;
  localparam logic [ADDR_W-1:0] A_EOS   = 6'h03;
  localparam logic [ADDR_W-1:0] A_LVL   = 6'h04;
  localparam logic [ADDR_W-1:0] A_PRIO0 = 6'h10;

  localparam int unsigned VEC_VALID_BIT = 8;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 31,
  parameter int unsigned LVL_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [N_SRC-1:0]            mask_o,
  output logic                        fen_o,
  output logic [N_SRC-1:0][LVL_W-1:0] prio_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      fen_o  <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_MASK) mask_o <= wdata_i[N_SRC-1:0];
      if (addr_i == A_FEN)  fen_o  <= wdata_i[0];
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_prio
    localparam logic [ADDR_W-1:0] MY_ADDR = A_PRIO0 + ADDR_W'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          prio_o[k] <= '0;
      else if (wr_i && addr_i == MY_ADDR)   prio_o[k] <= wdata_i[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int unsigned N_SRC = 31,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned ID_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            req_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] prio_i,
  output logic                        valid_o,
  output logic [ID_W-1:0]             id_o,
  output logic [LVL_W-1:0]            lvl_o
);
  // strict compare: the lowest index keeps a tie
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && prio_i[i] > lvl_o) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        lvl_o   = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic [SP_W-1:0]  sp_o
);
  logic [DEPTH-1:0][LVL_W-1:0] stk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q     <= '0;
      sp_o      <= '0;
      cur_lvl_o <= '0;
    end else if (push_i && sp_o < SP_W'(DEPTH)) begin
      stk_q[sp_o[SP_W-1:0]] <= cur_lvl_o;
      sp_o                  <= sp_o + 1'b1;
      cur_lvl_o             <= push_lvl_i;
    end else if (pop_i && sp_o != '0) begin
      sp_o      <= sp_o - 1'b1;
      cur_lvl_o <= stk_q[sp_o - 1'b1];
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> sp_o < SP_W'(DEPTH));

  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && sp_o == '0) |=> (cur_lvl_o == '0 && sp_o == '0));

  // R9
  pop_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && sp_o != '0) |=> sp_o == $past(sp_o) - 1'b1);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 31,
  parameter int unsigned LVL_W = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ID_W = $clog2(N_SRC),
  localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              fiq_src_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_SRC-1:0]            mask_q;
  logic                        fen_q;
  logic [N_SRC-1:0][LVL_W-1:0] prio_q;
  logic                        win_valid;
  logic [ID_W-1:0]             win_id;
  logic [LVL_W-1:0]            win_lvl;
  logic [LVL_W-1:0]            cur_lvl;
  logic [SP_W-1:0]             sp;
  logic [1:0]                  fiq_sync_q;
  logic                        wr, vec_rd, ack, eos;
  logic [ADDR_W-1:0]           prio_idx;

  assign wr     = reg_req_i && reg_we_i;
  assign vec_rd = reg_req_i && !reg_we_i && reg_addr_i == A_VEC;
  assign eos    = wr && reg_addr_i == A_EOS;

  irq_prio_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mask_o(mask_q), .fen_o(fen_q), .prio_o(prio_q)
  );

  irq_prio_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i(irq_src_i & mask_q), .prio_i(prio_q),
    .valid_o(win_valid), .id_o(win_id), .lvl_o(win_lvl)
  );

  assign irq_o = win_valid && win_lvl > cur_lvl;
  assign ack   = vec_rd && irq_o;

  irq_level_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni, .push_i(ack), .push_lvl_i(win_lvl), .pop_i(eos),
    .cur_lvl_o(cur_lvl), .sp_o(sp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fiq_sync_q <= '0;
    else         fiq_sync_q <= {fiq_sync_q[0], fiq_src_i};
  end
  assign fiq_o = fiq_sync_q[1] && fen_q;

  assign prio_idx = reg_addr_i - A_PRIO0;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_MASK: reg_rdata_o[N_SRC-1:0] = mask_q;
      A_FEN:  reg_rdata_o[0]         = fen_q;
      A_VEC: begin
        reg_rdata_o[VEC_VALID_BIT] = irq_o;
        if (irq_o) reg_rdata_o[ID_W-1:0] = win_id;
      end
      A_LVL:  reg_rdata_o[LVL_W-1:0] = cur_lvl;
      default:
        if (reg_addr_i >= A_PRIO0 && prio_idx < ADDR_W'(N_SRC))
          reg_rdata_o[LVL_W-1:0] = prio_q[prio_idx[ID_W-1:0]];
    endcase
  end

  // R6
  ack_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> cur_lvl == $past(win_lvl));

  // R10
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && !irq_o) |=> $stable(cur_lvl));

  // R7
  top_level_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_lvl == '1) |-> !irq_o);

  // R11
  fiq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> fen_q);

  // R2
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_src_i & mask_q) == '0) |-> !irq_o);
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] src = '0;
  logic        fsrc = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;
  logic [30:0] mask_m = '0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .fiq_src_i(fsrc),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic set_src(int k, logic v);
    @(negedge clk); src[k] = v; #1;
  endtask

  task automatic enable(int k);
    mask_m[k] = 1'b1;
    wr(6'h00, {1'b0, mask_m});
  endtask

  task automatic vec_expect(string tag, logic valid, int id);
    logic [31:0] d;
    rd(6'h02, d);
    chk({tag, " vec valid"}, {31'b0, d[8]}, {31'b0, valid});
    if (valid) chk({tag, " vec id"}, {27'b0, d[4:0]}, id);
  endtask

  task automatic lvl_expect(string tag, int lvl);
    logic [31:0] d;
    rd(6'h04, d);
    chk({tag, " level"}, d, lvl);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    lvl_expect("R1", 0);
    rd(6'h00, d); chk("R1 mask", d, 0);
    rd(6'h01, d); chk("R1 fast enable", d, 0);
  endtask

  task automatic t_mask_and_zero;
    logic [31:0] d;
    wr(6'h10 + 6'd3, 2);
    rd(6'h10 + 6'd3, d); chk("R12 prio readback", d, 2);
    set_src(3, 1'b1);
    chk("R2 masked src", {31'b0, irq}, 0);
    enable(3);
    #1 chk("R2 enabled src", {31'b0, irq}, 1);
    set_src(3, 1'b0);
    chk("R2 src dropped", {31'b0, irq}, 0);
    enable(5);
    set_src(5, 1'b1);
    chk("R3 level zero", {31'b0, irq}, 0);
    vec_expect("R3 R10", 1'b0, 0);
    lvl_expect("R10", 0);
    set_src(5, 1'b0);
  endtask

  task automatic t_nesting;
    wr(6'h10 + 6'd7, 5);
    wr(6'h10 + 6'd9, 5);
    wr(6'h10 + 6'd20, 6);
    wr(6'h10 + 6'd25, 7);
    enable(7); enable(9); enable(20); enable(25);
    set_src(3, 1'b1); set_src(7, 1'b1); set_src(9, 1'b1); set_src(20, 1'b1);
    vec_expect("R4 highest", 1'b1, 20);
    lvl_expect("R6 ack", 6);
    chk("R7 same level held", {31'b0, irq}, 0);
    set_src(20, 1'b0);
    chk("R7 lower held", {31'b0, irq}, 0);
    set_src(25, 1'b1);
    chk("R8 preempt", {31'b0, irq}, 1);
    vec_expect("R8 nested", 1'b1, 25);
    lvl_expect("R8 nested", 7);
    chk("R7 top level", {31'b0, irq}, 0);
    set_src(25, 1'b0);
    wr(6'h03, 0);
    lvl_expect("R9 pop once", 6);
    chk("R7 still held", {31'b0, irq}, 0);
    wr(6'h03, 0);
    lvl_expect("R9 pop twice", 0);
    chk("R7 released", {31'b0, irq}, 1);
    vec_expect("R5 tie", 1'b1, 7);
    lvl_expect("R6 tie ack", 5);
    wr(6'h03, 0);
    wr(6'h03, 0);
    lvl_expect("R9 empty pop", 0);
    src = '0;
  endtask

  task automatic t_fast;
    @(negedge clk); fsrc = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 disabled", {31'b0, fiq}, 0);
    @(negedge clk); fsrc = 1'b0;
    wr(6'h01, 1);
    repeat (2) @(negedge clk);
    fsrc = 1'b1;
    @(negedge clk);
    chk("R11 one edge", {31'b0, fiq}, 0);
    @(negedge clk);
    chk("R11 two edges", {31'b0, fiq}, 1);
    wr(6'h10 + 6'd1, 7); enable(1); set_src(1, 1'b1);
    vec_expect("R11 raise level", 1'b1, 1);
    lvl_expect("R11", 7);
    chk("R11 level ignored", {31'b0, fiq}, 1);
    @(negedge clk); fsrc = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 falls", {31'b0, fiq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_and_zero();
    t_nesting();
    t_fast();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule